// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This block holds the raw interrupt status of a serial controller for three events: transfer done, receive ready and receive overrun. Each event arrives as a one-cycle set pulse. Once set, a raw bit stays set until software clears it. Software clears a raw bit by writing a one to the matching bit of the clear register. The block gets that write as a strobe plus a data word, after the surrounding bus logic has decoded the address.

The interrupt enables live in the controller's control word, and their bit positions do not match the status layout. The block picks those enable bits out of the control word and reorders them into status order. It then ANDs them with the raw status to form the masked status. A single level-sensitive interrupt line is the OR of the masked bits.

The raw and masked status are outputs only. A bus write aimed at either address has no path into this block.

Top module: `mis_irq_unit`

## Requirements
- R1: Status bit positions are fixed. Bit 0 is transfer done, set by `evt_set_i[0]`. Bit 1 is receive ready, set by `evt_set_i[1]`. Bit 2 is receive overrun, set by `evt_set_i[2]`. A set pulse sampled at a rising edge makes the raw bit 1 after that edge, and the bit holds at 1 afterwards.
- R2: The enable for status bit 0 is control bit 5. The enable for status bit 1 is control bit 4. The enable for status bit 2 is control bit 6. No other control bit affects the masked status or the interrupt.
- R3: When `clr_we_i` is high and `clr_data_i[k]` is 1 (k = 0..2), raw bit k reads 0 after the edge, unless R8 applies.
- R4: A clear write leaves unchanged every raw bit whose data bit is 0. Clear data bits 31..3 have no effect. Clear data presented while `clr_we_i` is low has no effect.
- R5: `masked_o` equals the raw status ANDed with the reordered enables. It follows a change of `ctrl_word_i` in the same cycle, with no clock edge needed.
- R6: `irq_o` is 1 exactly when at least one masked bit is 1.
- R7: An active-low asynchronous reset clears the raw status at once. While the reset is held, set pulses are ignored, so the masked status and `irq_o` read 0.
- R8: If a set pulse and a clear arrive for the same bit in the same cycle, the bit reads 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_set_i | input | 3 | One-cycle event set pulses, in status bit order |
| ctrl_word_i | input | CTRL_W (32) | Control register contents; bits 6..4 carry the enables |
| clr_we_i | input | 1 | Write strobe for the clear register |
| clr_data_i | input | CLR_W (32) | Clear register write data; a one clears a bit |
| raw_o | output | 3 | Raw status |
| masked_o | output | 3 | Masked status |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume two things. First, each set pulse and clear strobe is stable around the rising edge. Second, a clear is only meaningful when both the strobe and its data bit are high. The bench therefore drives every input at the falling edge and releases the strobes right after the edge that samples them. The bench sweeps all raw states against all enable combinations, with the unrelated control bits held at 0 and then at 1. It also sweeps every combination of initial raw state, set pattern, clear pattern and strobe, with the upper clear data bits set to noise.

// File: rtl/mis_irq_pkg.sv
package mis_irq_pkg;
  localparam int unsigned EVT_W  = 3;
  localparam int unsigned CTRL_W = 32;
  localparam int unsigned CLR_W  = 32;

  typedef enum int unsigned {
    EVT_TX_DONE = 0,
    EVT_RX_RDY  = 1,
    EVT_RX_OVF  = 2
  } evt_e;

  // control-word position of the enable for each status bit
  function automatic int unsigned en_pos(int unsigned idx);
    case (idx)
      EVT_TX_DONE: en_pos = 5;
      EVT_RX_RDY:  en_pos = 4;
      default:     en_pos = 6;
    endcase
  endfunction
endpackage

// File: rtl/mis_enable_remap.sv
module mis_enable_remap
  import mis_irq_pkg::*;
#(
  parameter int unsigned CTRL_W = mis_irq_pkg::CTRL_W
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic [EVT_W-1:0]  en_o
);
  logic unused_ctrl;
  assign unused_ctrl = ^ctrl_i;

  for (genvar i = 0; i < EVT_W; i++) begin : g_en
    localparam int unsigned POS = en_pos(i);
    assign en_o[i] = ctrl_i[POS];
  end
endmodule

// File: rtl/mis_raw_bit.sv
module mis_raw_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;  // set has priority
    else if (clr_i) q_o <= 1'b0;
  end

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/mis_mask_combine.sv
module mis_mask_combine
  import mis_irq_pkg::*;
(
  input  logic [EVT_W-1:0] raw_i,
  input  logic [EVT_W-1:0] en_i,
  output logic [EVT_W-1:0] masked_o,
  output logic             irq_o
);
  assign masked_o = raw_i & en_i;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/mis_irq_unit.sv
module mis_irq_unit
  import mis_irq_pkg::*;
#(
  parameter int unsigned CTRL_W = mis_irq_pkg::CTRL_W,
  parameter int unsigned CLR_W  = mis_irq_pkg::CLR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  evt_set_i,
  input  logic [CTRL_W-1:0] ctrl_word_i,
  input  logic              clr_we_i,
  input  logic [CLR_W-1:0]  clr_data_i,
  output logic [EVT_W-1:0]  raw_o,
  output logic [EVT_W-1:0]  masked_o,
  output logic              irq_o
);
  logic [EVT_W-1:0] en;
  logic [EVT_W-1:0] clr_hit;
  logic             unused_clr;

  assign unused_clr = ^clr_data_i;
  assign clr_hit    = {EVT_W{clr_we_i}} & clr_data_i[EVT_W-1:0];

  mis_enable_remap #(.CTRL_W(CTRL_W)) u_remap (
    .ctrl_i (ctrl_word_i),
    .en_o   (en)
  );

  for (genvar i = 0; i < EVT_W; i++) begin : g_raw
    mis_raw_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_set_i[i]),
      .clr_i  (clr_hit[i]),
      .q_o    (raw_o[i])
    );
  end

  mis_mask_combine u_mask (
    .raw_i    (raw_o),
    .en_i     (en),
    .masked_o (masked_o),
    .irq_o    (irq_o)
  );

  assert_mask_subset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_o & ~raw_o) == '0);
  assert_irq_needs_raw_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw_o != '0));
  assert_set_seen_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_set_i != '0) |=> ((raw_o & $past(evt_set_i)) == $past(evt_set_i)));
endmodule

// File: tb/mis_irq_unit_tb.sv
`timescale 1ns/1ps
module mis_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  evt_set = '0;
  logic [31:0] ctrl = '0;
  logic        clr_we = 1'b0;
  logic [31:0] clr_data = '0;
  logic [2:0]  raw, masked;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic [2:0] exp_raw = '0;

  always #10 clk = ~clk;

  mis_irq_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .evt_set_i(evt_set), .ctrl_word_i(ctrl),
    .clr_we_i(clr_we), .clr_data_i(clr_data),
    .raw_o(raw), .masked_o(masked), .irq_o(irq)
  );

  // R2: status 0 <- ctrl 5, status 1 <- ctrl 4, status 2 <- ctrl 6
  function automatic logic [2:0] en_of(logic [31:0] c);
    return {c[6], c[4], c[5]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    logic [2:0] m;
    m = exp_raw & en_of(ctrl);
    check({req, " raw"}, 32'(raw), 32'(exp_raw));
    check({req, " masked"}, 32'(masked), 32'(m));
    check({req, " irq"}, 32'(irq), 32'(|m));
  endtask

  task automatic tick(logic [2:0] s, logic we, logic [31:0] d);
    @(negedge clk);
    evt_set = s; clr_we = we; clr_data = d;
    @(posedge clk);
    #2;
    exp_raw = s | (we ? (exp_raw & ~d[2:0]) : exp_raw);
    evt_set = '0; clr_we = 1'b0; clr_data = '0;
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R7: reset state, set pulses ignored under reset
    ctrl = 32'hFFFF_FFFF;
    evt_set = 3'b111;
    repeat (3) @(posedge clk);
    #2;
    exp_raw = '0;
    check_all("R7 reset");
    evt_set = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check_all("R7 after release");

    // R1/R2/R5/R6: all raw states against all enable combinations
    for (int s = 0; s < 8; s++) begin
      tick(3'b000, 1'b1, 32'h7);
      tick(3'(s), 1'b0, 32'h0);
      check(s == 0 ? "R1 raw zero" : "R1 raw set", 32'(raw), 32'(s));
      for (int n = 0; n < 2; n++) begin
        for (int e = 0; e < 8; e++) begin
          @(negedge clk);
          ctrl = (n == 0 ? 32'h0 : 32'hFFFF_FF8F) | (32'(e) << 4);
          #1;
          check_all(n == 0 ? "R5 mask" : "R2 other ctrl bits");
          check("R6 irq level", 32'(irq), 32'(|(3'(s) & en_of(ctrl))));
        end
      end
    end

    // R3/R4/R8: initial state x set x clear x strobe
    @(negedge clk);
    ctrl = 32'h0000_0070;
    for (int i0 = 0; i0 < 8; i0++)
      for (int s = 0; s < 8; s++)
        for (int c = 0; c < 8; c++)
          for (int w = 0; w < 2; w++) begin
            string tag;
            tick(3'b000, 1'b1, 32'h7);
            tick(3'(i0), 1'b0, 32'h0);
            tick(3'(s), w[0], {29'h1555_5555, 3'(c)});
            if (w == 1 && (s & c) != 0) tag = "R8 set wins";
            else if (w == 1 && c != 0)  tag = "R3 clear";
            else                        tag = "R4 no effect";
            check_all(tag);
          end

    // R7: asynchronous reset mid-cycle
    tick(3'b111, 1'b0, 32'h0);
    check_all("R7 preset");
    @(negedge clk);
    #3;
    rst_ni = 1'b0;
    #1;
    exp_raw = '0;
    check_all("R7 async clear");
    #3;
    rst_ni = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule